// File: doc/BRIEF.md
# Reset Supervisor with Pulse Stretching

This block generates a complementary pair of system reset signals, one active-low and one active-high, and models each as an open-drain style driver with its own output enable. Reset is forced whenever the synchronous supply-good flag is false. Once the supply is good, reset stays asserted for a fixed number of clock cycles and then both drivers release, leaving the line levels to external pull devices.

The two reset lines are also sensed back as inputs, so the block conditions resets applied from outside. A falling edge on the active-low line or a rising edge on the active-high line restarts the full stretch interval. Both sensed lines pass through a synchroniser before edge detection. Edges are ignored while the block is driving, because at that time any transition on the line comes from its own driver. A watchdog-expiry pulse restarts the interval in the same way. Any restart reloads the full count.

The stretch length is a parameter counted in clock cycles. A real design sets it to about 200 ms of clock time, and a simulation sets it to a few cycles.

Top module: `rst_stretcher`

## Requirements
- R1: While `supply_ok` is low, both enables are 1, `rst_n_o` is 0 and `rst_o` is 1.
- R2: After `supply_ok` rises, the enables stay 1 for the cycle in which it rises plus STRETCH_CYCLES-1 further cycles, STRETCH_CYCLES cycles in all with supply good, and then go to 0.
- R3: When `supply_ok` falls, the outputs go active in the same cycle, before the next clock edge, with no counter delay.
- R4: A high-to-low transition on `rst_n_sense` while the block is not driving makes the enables go high at the (SYNC_STAGES+1)-th rising clock edge after the change and stay high for STRETCH_CYCLES cycles.
- R5: A low-to-high transition on `rst_sense` while the block is not driving has the same effect, with the same latency and the same length.
- R6: A sensed line held at a constant level, even the active one, starts no further interval. The opposite transition (low-to-high on `rst_n_sense`, high-to-low on `rst_sense`) starts nothing.
- R7: `wdt_expire` high at a clock edge with the supply good sets the enables high from that edge for STRETCH_CYCLES cycles.
- R8: A restart during an active interval reloads the full STRETCH_CYCLES count from the edge that samples it.
- R9: Transitions on the sensed lines caused by the block's own driving, at drive start and at release, do not restart the interval.
- R10: The two enables are always equal, and `rst_o` is always the inverse of `rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Synchronous supply-good flag. Low forces reset |
| rst_n_sense | input | 1 | Sensed level of the active-low reset line |
| rst_sense | input | 1 | Sensed level of the active-high reset line |
| wdt_expire | input | 1 | Watchdog expiry pulse. Restarts the interval |
| rst_n_o | output | 1 | Active-low reset level, 0 while driving |
| rst_n_oe | output | 1 | Driver enable for the active-low line |
| rst_o | output | 1 | Active-high reset level, 1 while driving |
| rst_oe | output | 1 | Driver enable for the active-high line |

## Verification
A corrupted stretch counter shows up as a reset pulse of the wrong length, which the bench measures to the exact cycle. A faulty edge detector or a missing drive mask shows up in one of two ways: the enables never fall because the block keeps retriggering on its own edges, or an external edge is lost. Both are visible within about STRETCH_CYCLES plus SYNC_STAGES+1 cycles of the stimulus. A bad synchroniser depth changes the measured trigger latency directly.

// File: rtl/rst_stretcher.sv
module rst_stretcher #(
  parameter int unsigned STRETCH_CYCLES = 5_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic rst_n_sense,
  input  logic rst_sense,
  input  logic wdt_expire,
  output logic rst_n_o,
  output logic rst_n_oe,
  output logic rst_o,
  output logic rst_oe
);

  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(STRETCH_CYCLES);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] n_sync, p_sync;
  logic n_last, p_last;
  logic [CW-1:0] cnt;
  logic hold, driving, n_fall, p_rise, restart;

  assign hold    = (cnt != '0);
  assign driving = !supply_ok || hold;
  assign n_fall  = n_last && !n_sync[TOP];
  assign p_rise  = !p_last && p_sync[TOP];
  assign restart = wdt_expire || (!hold && (n_fall || p_rise));

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!supply_ok) begin
          n_sync <= '0;
          p_sync <= '1;
        end else begin
          n_sync <= rst_n_sense;
          p_sync <= rst_sense;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!supply_ok) begin
          n_sync <= '0;
          p_sync <= '1;
        end else begin
          n_sync <= {n_sync[SYNC_STAGES-2:0], rst_n_sense};
          p_sync <= {p_sync[SYNC_STAGES-2:0], rst_sense};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      n_last <= 1'b0;
      p_last <= 1'b1;
      cnt    <= FULL;
    end else begin
      n_last <= n_sync[TOP];
      p_last <= p_sync[TOP];
      if (restart)   cnt <= FULL;
      else if (hold) cnt <= cnt - 1'b1;
    end
  end

  assign rst_n_oe = driving;
  assign rst_oe   = driving;
  assign rst_n_o  = !driving;
  assign rst_o    = driving;

endmodule

// File: rtl/rst_stretcher_chk.sv
module rst_stretcher_chk #(
  parameter int unsigned STRETCH_CYCLES = 5_000_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input logic clk,
  input logic supply_ok,
  input logic wdt_expire,
  input logic rst_n_o,
  input logic rst_n_oe,
  input logic rst_o,
  input logic rst_oe
);

  localparam int unsigned RW = $clog2(STRETCH_CYCLES + 2);
  localparam logic [RW-1:0] MIN_RUN = RW'(STRETCH_CYCLES);

  logic [RW-1:0] run = '0;

  always_ff @(posedge clk) begin
    if (!rst_oe)        run <= '0;
    else if (run != '1) run <= run + 1'b1;
  end

  assert_supply_low_active_R1: assert property (@(posedge clk)
    !supply_ok |-> (rst_oe && rst_n_oe && rst_o && !rst_n_o));

  assert_pulse_min_width_R2: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(rst_oe) |-> (run >= MIN_RUN));

  assert_wdt_asserts_R7: assert property (@(posedge clk) disable iff (!supply_ok)
    wdt_expire |=> rst_oe);

  assert_pair_consistent_R10: assert property (@(posedge clk) disable iff (!supply_ok)
    (rst_oe == rst_n_oe) && (rst_o == !rst_n_o));

endmodule

bind rst_stretcher rst_stretcher_chk #(
  .STRETCH_CYCLES(STRETCH_CYCLES),
  .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk),
  .supply_ok(supply_ok),
  .wdt_expire(wdt_expire),
  .rst_n_o(rst_n_o),
  .rst_n_oe(rst_n_oe),
  .rst_o(rst_o),
  .rst_oe(rst_oe)
);

// File: tb/rst_stretcher_tb_top.sv
module rst_stretcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic supply_ok = 1'b0;
  logic ext_n = 1'b1;
  logic ext_p = 1'b0;
  logic wdt = 1'b0;
  logic rst_n_o, rst_n_oe, rst_o, rst_oe;
  logic sense_n, sense_p;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sense_n = rst_n_oe ? rst_n_o : ext_n;
  assign sense_p = rst_oe ? rst_o : ext_p;

  rst_stretcher #(.STRETCH_CYCLES(S), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .supply_ok(supply_ok), .rst_n_sense(sense_n), .rst_sense(sense_p),
    .wdt_expire(wdt), .rst_n_o(rst_n_o), .rst_n_oe(rst_n_oe), .rst_o(rst_o), .rst_oe(rst_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int lead, output int ones, output int split);
    lead = 0; ones = 0; split = 0;
    #1;
    while (!rst_oe && lead < 50) begin @(negedge clk); lead++; end
    while (rst_oe && ones < 10*S) begin
      if (rst_oe != rst_n_oe || rst_o == rst_n_o) split++;
      ones++;
      @(negedge clk);
    end
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int hits = 0;
    repeat (cycles) begin @(negedge clk); if (rst_oe || rst_n_oe) hits++; end
    check(hits == 0, req, hits, 0);
  endtask

  task automatic pulse_wdt();
    @(negedge clk); wdt = 1'b1;
    @(negedge clk); wdt = 1'b0;
  endtask

  task automatic t_reset_state();
    repeat (5) @(negedge clk);
    check(rst_oe == 1'b1,   "R1 rst_oe",   rst_oe, 1);
    check(rst_n_oe == 1'b1, "R1 rst_n_oe", rst_n_oe, 1);
    check(rst_n_o == 1'b0,  "R1 rst_n_o",  rst_n_o, 0);
    check(rst_o == 1'b1,    "R1 rst_o",    rst_o, 1);
  endtask

  task automatic t_power_up();
    int lead, ones, split;
    @(negedge clk); supply_ok = 1'b1;
    measure(lead, ones, split);
    check(ones == S, "R2 power-up stretch", ones, S);
    check(split == 0, "R10 outputs agree", split, 0);
    expect_quiet(3*S, "R9 no retrigger after release");
  endtask

  task automatic t_low_pin_edge();
    int lead, ones, split;
    @(negedge clk); ext_n = 1'b0;
    measure(lead, ones, split);
    check(lead == SYNC+1, "R4 latency", lead, SYNC+1);
    check(ones == S, "R4 stretch", ones, S);
    check(split == 0, "R10 outputs agree", split, 0);
    expect_quiet(3*S, "R6 held low no restart");
    ext_n = 1'b1;
    expect_quiet(2*S, "R6 low-pin rise ignored");
  endtask

  task automatic t_high_pin_edge();
    int lead, ones, split;
    @(negedge clk); ext_p = 1'b1;
    measure(lead, ones, split);
    check(lead == SYNC+1, "R5 latency", lead, SYNC+1);
    check(ones == S, "R5 stretch", ones, S);
    expect_quiet(3*S, "R6 held high no restart");
    ext_p = 1'b0;
    expect_quiet(2*S, "R6 high-pin fall ignored");
  endtask

  task automatic t_watchdog();
    int lead, ones, split;
    pulse_wdt();
    measure(lead, ones, split);
    check(lead == 0, "R7 immediate", lead, 0);
    check(ones == S, "R7 stretch", ones, S);
    expect_quiet(3*S, "R9 own edges ignored");
  endtask

  task automatic t_reload();
    int lead, ones, split;
    pulse_wdt();
    repeat (3) @(negedge clk);
    check(rst_oe == 1'b1, "R8 active before retrigger", rst_oe, 1);
    pulse_wdt();
    measure(lead, ones, split);
    check(ones == S, "R8 full reload", ones, S);
    expect_quiet(2*S, "R8 quiet after");
  endtask

  task automatic t_supply_loss();
    int lead, ones, split;
    @(negedge clk); supply_ok = 1'b0;
    #1;
    check(rst_oe == 1'b1,  "R3 same-cycle enable", rst_oe, 1);
    check(rst_n_o == 1'b0, "R3 same-cycle level", rst_n_o, 0);
    repeat (4) @(negedge clk);
    check(rst_n_oe == 1'b1, "R1 held while low", rst_n_oe, 1);
    supply_ok = 1'b1;
    measure(lead, ones, split);
    check(ones == S, "R2 stretch after recovery", ones, S);
    expect_quiet(2*S, "R9 quiet after recovery");
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_power_up();
    t_low_pin_edge();
    t_high_pin_edge();
    t_watchdog();
    t_reload();
    t_supply_loss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule